// File: doc/BRIEF.md
# JTAG Streaming Datagram Bridge

This block lives inside a chip behind a user-defined JTAG data register. Once the host has selected it through the instruction register and parked the TAP in SHIFT-DR with TCK running freely, every TCK cycle moves one bit in each direction. The bridge turns that endless scan into two separate word streams that both run on TCK. Outbound datagram words from the on-chip interconnect are buffered, framed with a start marker and shifted out on TDO. Inbound TDI bits are searched for the same marker, and the framed words that follow come out on a valid/ready port.

Between datagrams the transmitter shifts all-zero filler words. A datagram leaves only when every one of its words is already queued, so it never stalls halfway. The receiver hunts for the marker one bit at a time. Word alignment therefore comes from where the marker ends and not from any count since shifting began. Each datagram is the marker, then a header word whose low bits give the payload length in words, then exactly that many payload words.

Top module: `jtag_stream_bridge`

## Requirements
- R1: While `tap_reset_n` is low and right after it rises, `tdo`=0, `rx_valid`=0, `rx_overflow`=0 and `tx_ready`=1, and the transmit queue is empty.
- R2: Bits shift only in cycles where `sel` and `shift_dr` are both 1. In any other cycle `tdo` holds its value and the receiver takes in no bits.
- R3: When no complete datagram is queued, `tdo` carries filler words that are all zeros.
- R4: A datagram goes out on `tdo` as a 32-bit marker word 0xD5555555, then the header, then the payload words, all back to back and each least-significant bit first. On the wire the marker reads as bytes 0x55, 0x55, 0x55, 0xD5, in that order, each byte LSB first.
- R5: Header bits [15:0] give the payload length N. Transmission of a datagram starts only once its header and all N payload words are queued, and no filler word is ever placed inside a datagram.
- R6: The receiver matches the marker on each bit of `tdi`, at any bit offset. It then delivers the header and N payload words (N from header bits [15:0]) on `rx_data` and goes back to searching.
- R7: A received word is on `rx_data` with `rx_valid`=1 in the cycle after the clock edge that shifts in its last bit. It stays there until a cycle with `rx_ready`=1.
- R8: If a word completes while `rx_valid`=1 and `rx_ready`=0, that word is dropped, the held word is kept, and `rx_overflow` goes to 1. It stays at 1 until `tap_reset_n` is asserted.
- R9: A cycle with `sel` and `capture` both 1 abandons any datagram in progress and returns the receiver to marker search.
- R10: With `tdo` looped back to `tdi`, the words queued on `tx_data` come out on `rx_data` unchanged and in order, header words included.
- R11: `tx_ready` is 0 while the transmit queue holds FIFO_DEPTH words. A word is accepted in a cycle with `tx_valid`=1 and `tx_ready`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; every register in the block uses its rising edge |
| tap_reset_n | input | 1 | Active-low asynchronous reset, driven while the TAP is in test-logic-reset |
| sel | input | 1 | The bridge's user instruction is loaded in the instruction register |
| shift_dr | input | 1 | TAP is in SHIFT-DR |
| capture | input | 1 | TAP is in CAPTURE-DR |
| tdi | input | 1 | Serial data from the host |
| tdo | output | 1 | Serial data to the host |
| tx_data | input | WORD_W | Outbound datagram word |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Transmit queue has room |
| rx_data | output | WORD_W | Received datagram word |
| rx_valid | output | 1 | `rx_data` holds an undelivered word |
| rx_ready | input | 1 | Consumer takes `rx_data` this cycle |
| rx_overflow | output | 1 | Sticky: a received word was dropped |

## Verification
A received word is due at the first falling edge after the rising edge that shifts in its last bit. A transmitted bit appears on `tdo` half a cycle after the rising edge that loads or shifts it. A queued datagram's marker begins within one word time (32 cycles) of the datagram becoming complete. The bench drives `tdi` and strobes at falling edges and samples every output at falling edges, so each comparison falls in the half cycle after the edge that produced the value. Serial sequences are checked by capturing whole 64-bit windows starting at the first set bit, and the overflow and hold checks run at the falling edge right after the offending word's last bit.

// File: rtl/jsb_pkg.sv
package jsb_pkg;

   typedef enum logic [1:0] {
      RX_HUNT = 2'd0,
      RX_HDR  = 2'd1,
      RX_PAY  = 2'd2
   } rx_state_e;

   // Marker word; shifted LSB first it reads 0x55 0x55 0x55 0xD5
   localparam logic [31:0] DEFAULT_MARKER = 32'hD555_5555;

endpackage

// File: rtl/jsb_tx_fifo.sv
module jsb_tx_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 8,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  push_data,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic [CW-1:0] count,
   output logic          full
);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign head = mem[rd_ptr];
   assign full = (count == CW'(DEPTH));

endmodule

// File: rtl/jsb_tx_serializer.sv
module jsb_tx_serializer #(
   parameter int             W      = 32,
   parameter int             LEN_W  = 16,
   parameter int             CW     = 4,
   parameter logic [W-1:0]   MARKER = '1,
   localparam int            BW     = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [W-1:0]  head,
   input  logic [CW-1:0] count,
   output logic          pop,
   output logic          tdo
);

   logic [W-1:0]   sreg, next_word;
   logic [BW-1:0]  bit_cnt;
   logic           in_dgram, start, last_bit;
   logic [LEN_W:0] words_left, need;

   assign last_bit = (bit_cnt == BW'(W - 1));
   assign need     = {1'b0, head[LEN_W-1:0]} + 1'b1;

   // choose the word that follows at the next word boundary
   always_comb begin
      next_word = '0;
      start     = 1'b0;
      pop       = 1'b0;
      if (in_dgram) begin
         next_word = head;
         pop       = en && last_bit;
      end else if (count != '0 && need <= (LEN_W + 1)'(count)) begin
         next_word = MARKER;
         start     = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg       <= '0;
         bit_cnt    <= '0;
         in_dgram   <= 1'b0;
         words_left <= '0;
      end else if (en) begin
         bit_cnt <= bit_cnt + 1'b1;
         if (last_bit) begin
            sreg <= next_word;
            if (start) begin
               in_dgram   <= 1'b1;
               words_left <= need;
            end else if (in_dgram) begin
               words_left <= words_left - 1'b1;
               if (words_left == (LEN_W + 1)'(1)) in_dgram <= 1'b0;
            end
         end else begin
            sreg <= {1'b0, sreg[W-1:1]};
         end
      end
   end

   assign tdo = sreg[0];

endmodule

// File: rtl/jsb_rx_deframer.sv
module jsb_rx_deframer #(
   parameter int           W      = 32,
   parameter int           LEN_W  = 16,
   parameter logic [W-1:0] MARKER = '1,
   localparam int          BW     = $clog2(W)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         restart,
   input  logic         tdi,
   input  logic         rx_ready,
   output logic [W-1:0] rx_data,
   output logic         rx_valid,
   output logic         overflow
);

   import jsb_pkg::*;

   rx_state_e        state;
   logic [W-1:0]     hist, word_now;
   logic [BW-1:0]    bit_cnt;
   logic [LEN_W-1:0] remain;
   logic             last_bit, word_done;

   assign word_now  = {tdi, hist[W-1:1]};
   assign last_bit  = (bit_cnt == BW'(W - 1));
   assign word_done = en && !restart && (state != RX_HUNT) && last_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= RX_HUNT;
         hist    <= '0;
         bit_cnt <= '0;
         remain  <= '0;
      end else if (restart) begin
         state   <= RX_HUNT;
         hist    <= '0;
         bit_cnt <= '0;
      end else if (en) begin
         hist <= word_now;
         unique case (state)
            RX_HUNT: begin
               if (word_now == MARKER) begin
                  state   <= RX_HDR;
                  bit_cnt <= '0;
               end
            end
            RX_HDR: begin
               bit_cnt <= bit_cnt + 1'b1;
               if (last_bit) begin
                  if (word_now[LEN_W-1:0] == '0) begin
                     state <= RX_HUNT;
                  end else begin
                     state  <= RX_PAY;
                     remain <= word_now[LEN_W-1:0];
                  end
               end
            end
            RX_PAY: begin
               bit_cnt <= bit_cnt + 1'b1;
               if (last_bit) begin
                  remain <= remain - 1'b1;
                  if (remain == LEN_W'(1)) state <= RX_HUNT;
               end
            end
            default: state <= RX_HUNT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data  <= '0;
         rx_valid <= 1'b0;
         overflow <= 1'b0;
      end else begin
         if (rx_valid && rx_ready) rx_valid <= 1'b0;
         if (word_done) begin
            if (rx_valid && !rx_ready) begin
               overflow <= 1'b1;
            end else begin
               rx_valid <= 1'b1;
               rx_data  <= word_now;
            end
         end
      end
   end

endmodule

// File: rtl/jtag_stream_bridge.sv
module jtag_stream_bridge #(
   parameter int                WORD_W     = 32,
   parameter int                LEN_W      = 16,
   parameter int                FIFO_DEPTH = 8,
   parameter logic [WORD_W-1:0] MARKER     = WORD_W'(jsb_pkg::DEFAULT_MARKER)
) (
   input  logic              tck,
   input  logic              tap_reset_n,
   input  logic              sel,
   input  logic              shift_dr,
   input  logic              capture,
   input  logic              tdi,
   output logic              tdo,
   input  logic [WORD_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic [WORD_W-1:0] rx_data,
   output logic              rx_valid,
   input  logic              rx_ready,
   output logic              rx_overflow
);

   localparam int CW = $clog2(FIFO_DEPTH + 1);

   generate
      if ((WORD_W & (WORD_W - 1)) != 0 || WORD_W < 8) begin : g_bad_word
         $error("WORD_W must be a power of two of at least 8");
      end
      if (LEN_W < 1 || LEN_W > WORD_W) begin : g_bad_len
         $error("LEN_W must lie between 1 and WORD_W");
      end
      if (FIFO_DEPTH < 2 || CW > LEN_W + 1) begin : g_bad_depth
         $error("FIFO_DEPTH out of range");
      end
      if (MARKER == '0) begin : g_bad_marker
         $error("MARKER must differ from the all-zero filler word");
      end
   endgenerate

   logic              shift_en, restart, fifo_full, fifo_push, fifo_pop;
   logic [WORD_W-1:0] fifo_head;
   logic [CW-1:0]     fifo_count;

   assign shift_en  = sel && shift_dr;
   assign restart   = sel && capture;
   assign tx_ready  = !fifo_full;
   assign fifo_push = tx_valid && !fifo_full;

   jsb_tx_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) i_fifo (
      .clk       (tck),
      .rst_n     (tap_reset_n),
      .push      (fifo_push),
      .push_data (tx_data),
      .pop       (fifo_pop),
      .head      (fifo_head),
      .count     (fifo_count),
      .full      (fifo_full)
   );

   jsb_tx_serializer #(.W(WORD_W), .LEN_W(LEN_W), .CW(CW), .MARKER(MARKER)) i_ser (
      .clk   (tck),
      .rst_n (tap_reset_n),
      .en    (shift_en),
      .head  (fifo_head),
      .count (fifo_count),
      .pop   (fifo_pop),
      .tdo   (tdo)
   );

   jsb_rx_deframer #(.W(WORD_W), .LEN_W(LEN_W), .MARKER(MARKER)) i_rx (
      .clk      (tck),
      .rst_n    (tap_reset_n),
      .en       (shift_en),
      .restart  (restart),
      .tdi      (tdi),
      .rx_ready (rx_ready),
      .rx_data  (rx_data),
      .rx_valid (rx_valid),
      .overflow (rx_overflow)
   );

endmodule

// File: rtl/jsb_checker.sv
module jsb_checker #(
   parameter int WORD_W = 32
) (
   input logic              tck,
   input logic              tap_reset_n,
   input logic              sel,
   input logic              shift_dr,
   input logic              tdo,
   input logic [WORD_W-1:0] rx_data,
   input logic              rx_valid,
   input logic              rx_ready,
   input logic              rx_overflow
);

   assert_tdo_frozen_R2: assert property (@(posedge tck) disable iff (!tap_reset_n)
      !(sel && shift_dr) |=> $stable(tdo));

   assert_no_rx_when_frozen_R2: assert property (@(posedge tck) disable iff (!tap_reset_n)
      (!(sel && shift_dr) && !rx_valid) |=> !rx_valid);

   assert_rx_hold_R7: assert property (@(posedge tck) disable iff (!tap_reset_n)
      (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

   assert_overflow_sticky_R8: assert property (@(posedge tck) disable iff (!tap_reset_n)
      rx_overflow |=> rx_overflow);

   assert_overflow_cause_R8: assert property (@(posedge tck) disable iff (!tap_reset_n)
      $rose(rx_overflow) |-> $past(rx_valid && !rx_ready));

endmodule

bind jtag_stream_bridge jsb_checker #(.WORD_W(WORD_W)) i_jsb_checker (
   .tck         (tck),
   .tap_reset_n (tap_reset_n),
   .sel         (sel),
   .shift_dr    (shift_dr),
   .tdo         (tdo),
   .rx_data     (rx_data),
   .rx_valid    (rx_valid),
   .rx_ready    (rx_ready),
   .rx_overflow (rx_overflow)
);

// File: tb/test_jtag_stream_bridge.sv
module test_jtag_stream_bridge;

   localparam logic [31:0] MK = {8'hD5, 8'h55, 8'h55, 8'h55};
   localparam int NV = 8;
   // three datagrams: queued words, which also come back in this order
   localparam logic [31:0] VEC [NV] = '{
      32'hABCD_0002, 32'h1111_1111, 32'h2222_2222,
      32'h5A5A_0000,
      32'h0000_0003, 32'hDEAD_BEEF, 32'h0000_0000, 32'hFFFF_FFFF };

   logic        tck = 1'b0;
   logic        tap_reset_n = 1'b0;
   logic        sel = 1'b0, shift_dr = 1'b0, capture = 1'b0;
   logic        tdi_drv = 1'b0, loopback = 1'b0;
   logic        tdi, tdo;
   logic [31:0] tx_data = '0;
   logic        tx_valid = 1'b0, tx_ready;
   logic [31:0] rx_data;
   logic        rx_valid, rx_overflow;
   logic        rx_ready = 1'b1;

   int checks = 0, failures = 0;
   logic [31:0] got [64];
   int ng = 0;
   int tdo_ones = 0;

   always #5 tck = ~tck;
   assign tdi = loopback ? tdo : tdi_drv;

   jtag_stream_bridge i_jtag_stream_bridge (
      .tck(tck), .tap_reset_n(tap_reset_n), .sel(sel), .shift_dr(shift_dr),
      .capture(capture), .tdi(tdi), .tdo(tdo), .tx_data(tx_data),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_overflow(rx_overflow));

   always @(negedge tck) begin
      if (tdo) tdo_ones = tdo_ones + 1;
      if (rx_valid && rx_ready && ng < 64) begin
         got[ng] = rx_data;
         ng = ng + 1;
      end
   end

   task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge tck);
   endtask

   task automatic do_reset();
      tap_reset_n = 1'b0;
      tick(2);
      tap_reset_n = 1'b1;
      tick(1);
   endtask

   task automatic push(input logic [31:0] w);
      tx_data = w; tx_valid = 1'b1;
      tick(1);
      tx_valid = 1'b0;
   endtask

   task automatic send_bits(input logic [31:0] w, input int n);
      for (int i = 0; i < n; i++) begin
         tdi_drv = w[i];
         tick(1);
      end
      tdi_drv = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge tck);
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
      $finish;
   end

   initial begin
      int base, ones0, pos;
      logic [63:0] bits;
      tick(3);
      // R1 reset state
      check(tdo == 1'b0, "R1 tdo", 64'(tdo), 64'd0);
      check(rx_valid == 1'b0, "R1 rx_valid", 64'(rx_valid), 64'd0);
      check(rx_overflow == 1'b0, "R1 rx_overflow", 64'(rx_overflow), 64'd0);
      check(tx_ready == 1'b1, "R1 tx_ready", 64'(tx_ready), 64'd1);
      do_reset();

      // R3 empty queue: filler zeros
      sel = 1'b1; shift_dr = 1'b1;
      ones0 = tdo_ones;
      tick(64);
      check(tdo_ones == ones0, "R3 filler zeros", 64'(tdo_ones - ones0), 64'd0);

      // R2 deselected: nothing shifts either way
      do_reset();
      sel = 1'b0;
      base = ng; ones0 = tdo_ones;
      push(32'h1234_0000);
      send_bits(MK, 32);
      send_bits(32'h0000_0000, 32);
      tick(40);
      check(tdo_ones == ones0, "R2 tdo frozen", 64'(tdo_ones - ones0), 64'd0);
      check(ng == base, "R2 rx frozen", 64'(ng - base), 64'd0);

      // R4 serial framing of the queued header-only datagram
      sel = 1'b1;
      pos = -1;
      for (int i = 0; i < 40; i++) begin
         if (tdo && pos < 0) pos = i;
         if (pos < 0) tick(1);
      end
      for (int i = 0; i < 64; i++) begin
         bits[i] = tdo;
         tick(1);
      end
      check(bits == {32'h1234_0000, MK}, "R4 marker+header bits", bits, {32'h1234_0000, MK});

      // R5 start only when complete, no filler inside
      do_reset();
      sel = 1'b1; shift_dr = 1'b1; loopback = 1'b1;
      base = ng;
      push(32'h7777_0002);
      push(32'hAAAA_5555);
      ones0 = tdo_ones;
      tick(100);
      check(tdo_ones == ones0, "R5 held until complete", 64'(tdo_ones - ones0), 64'd0);
      push(32'h0F0F_0F0F);
      tick(200);
      check(ng - base == 3, "R5 word count", 64'(ng - base), 64'd3);
      check(got[base] == 32'h7777_0002 && got[base+1] == 32'hAAAA_5555 && got[base+2] == 32'h0F0F_0F0F,
            "R5 words", {got[base], got[base+2]}, {32'h7777_0002, 32'h0F0F_0F0F});

      // R11 queue full, then R10 loopback over the vector table
      do_reset();
      sel = 1'b0; loopback = 1'b0;
      for (int i = 0; i < NV; i++) push(VEC[i]);
      check(tx_ready == 1'b0, "R11 full", 64'(tx_ready), 64'd0);
      base = ng;
      sel = 1'b1; loopback = 1'b1;
      tick(500);
      check(ng - base == NV, "R10 count", 64'(ng - base), 64'(NV));
      for (int i = 0; i < NV; i++)
         check(got[base+i] == VEC[i], "R10 word", 64'(got[base+i]), 64'(VEC[i]));
      check(tx_ready == 1'b1, "R11 drained", 64'(tx_ready), 64'd1);

      // R6 bit-level search at odd offsets
      do_reset();
      loopback = 1'b0; sel = 1'b1; shift_dr = 1'b1;
      base = ng;
      send_bits(32'h0, 7);
      send_bits(MK, 32);
      send_bits(32'hC0DE_0001, 32);
      send_bits(32'h8000_0001, 32);
      send_bits(32'h0, 13);
      send_bits(MK, 32);
      send_bits(32'hBEE5_0000, 32);
      send_bits(32'h0, 40);
      check(ng - base == 3, "R6 count", 64'(ng - base), 64'd3);
      check(got[base] == 32'hC0DE_0001 && got[base+1] == 32'h8000_0001 && got[base+2] == 32'hBEE5_0000,
            "R6 words", {got[base], got[base+1]}, {32'hC0DE_0001, 32'h8000_0001});

      // R9 capture abandons a datagram in progress
      base = ng;
      send_bits(MK, 32);
      send_bits(32'h0000_0003, 32);
      send_bits(32'h1111_2222, 32);
      shift_dr = 1'b0; capture = 1'b1;
      tick(1);
      capture = 1'b0; shift_dr = 1'b1;
      send_bits(MK, 32);
      send_bits(32'hFACE_0000, 32);
      tick(3);
      check(ng - base == 3, "R9 count", 64'(ng - base), 64'd3);
      check(got[base+2] == 32'hFACE_0000, "R9 new header", 64'(got[base+2]), 64'hFACE_0000);

      // R7 / R8 hold and overflow
      do_reset();
      rx_ready = 1'b0;
      send_bits(MK, 32);
      send_bits(32'h0BAD_0001, 32);
      check(rx_valid == 1'b1 && rx_data == 32'h0BAD_0001, "R7 word due", {31'd0, rx_valid, rx_data}, {32'd1, 32'h0BAD_0001});
      check(rx_overflow == 1'b0, "R8 no early overflow", 64'(rx_overflow), 64'd0);
      send_bits(32'h1234_5678, 32);
      check(rx_overflow == 1'b1, "R8 overflow set", 64'(rx_overflow), 64'd1);
      check(rx_data == 32'h0BAD_0001, "R8 held word kept", 64'(rx_data), 64'h0BAD_0001);
      rx_ready = 1'b1;
      tick(1);
      check(rx_valid == 1'b0, "R7 released", 64'(rx_valid), 64'd0);
      tick(5);
      check(rx_overflow == 1'b1, "R8 sticky", 64'(rx_overflow), 64'd1);
      do_reset();
      check(rx_overflow == 1'b0, "R8 cleared by reset", 64'(rx_overflow), 64'd0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule